// File: doc/BRIEF.md
# Write-Once Startup Option Register

This block holds one 8-bit set of system option bits on a simple memory-mapped bus. The bits are sent straight to the parts of the chip that use them. Three of the bits are ordinary and software may rewrite them at any moment. Four of the bits choose startup behaviour, so they are guarded. In normal operation they take a single write, and only in a short window right after reset. After that they are frozen until the next reset. One bit position is not implemented.

A mode input selects normal or special operation. In special operation the guarded bits stay writable for as long as the part runs. The register also sits in a 64-byte register block, and in special operation that block can be moved to the start of any 4 KB page. The page is taken from a 4-bit page input. In normal operation the block stays at a fixed page set by a parameter.

Top module: `sysopt_reg`

## Requirements
- R1: Out of reset the register reads 0x10. Only bit 4 (delay enable) is 1.
- R2: Bits 7 (analog power-up), 6 (clock select) and 3 (clock monitor enable) take the written value on every write that hits the register, in both modes and at any time.
- R3: Bit 2 always reads 0, and writes to it are ignored.
- R4: Guarded bits are 5 (interrupt edge select), 4 (delay enable), 1 and 0 (timing rate). In normal mode (special_mode=0), a write to these bits is accepted if it is the first hit write after reset and it lands on clock edge 0 to 63. Edge 0 is the first rising edge after reset is released, so edge 63 is the 64th edge.
- R5: In normal mode, once one hit write has been accepted, later writes do not change the guarded bits. The free bits in those same writes still update.
- R6: In normal mode, a write on edge 64 or any later edge leaves the guarded bits unchanged. The free bits in that write still update.
- R7: In special mode (special_mode=1), the guarded bits accept any number of writes at any time.
- R8: The register's address is page*0x1000 + 0x39. Here page is page_sel when special_mode=1, and the parameter HOME_PAGE (default 1) when special_mode=0. Writes to any other address change nothing.
- R9: rdata shows the register when rd_en is high and addr hits the register. Otherwise rdata is 0.
- R10: opt_bits always shows the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 selects special operation |
| page_sel | input | 4 | Register-block page, used in special mode |
| addr | input | 16 | Bus address |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| opt_bits | output | 8 | Current option bits for the system |

## Verification
The assertions assume that special_mode and page_sel stay steady between resets. They also assume that the checker's own edge counter advances in step with the block's window counter, because both are cleared by the same reset. The stimulus sets the mode only while reset is held and never changes it during a run. Every bus input is driven on the falling clock edge, so each write is seen on exactly one known edge number.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
   localparam int OPT_W        = 8;
   localparam int BLK_OFF_W    = 6;
   localparam logic [OPT_W-1:0] OPT_RESET  = 8'h10;
   localparam logic [OPT_W-1:0] OPT_GUARD  = 8'h33;
   localparam logic [OPT_W-1:0] OPT_IMPL   = 8'hFB;
   localparam logic [BLK_OFF_W-1:0] OPT_OFFSET = 6'h39;

   typedef enum logic [1:0] {
      BIT_ABSENT = 2'd0,
      BIT_FREE   = 2'd1,
      BIT_GUARD  = 2'd2
   } bit_kind_e;

   function automatic bit_kind_e kind_of(input logic impl, input logic guard);
      if (!impl)      return BIT_ABSENT;
      else if (guard) return BIT_GUARD;
      else            return BIT_FREE;
   endfunction
endpackage

// File: rtl/sysopt_addr_dec.sv
module sysopt_addr_dec #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 4,
   parameter int OFF_W  = 6,
   parameter logic [OFF_W-1:0] OFFSET = 6'h39
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [PAGE_W-1:0] page,
   output logic              hit
);
   localparam int GAP_W = ADDR_W - PAGE_W - OFF_W;

   if (GAP_W < 1) begin : g_bad_width
      $error("sysopt_addr_dec: address too narrow for page and offset");
   end

   logic page_ok, gap_ok, off_ok;

   always_comb begin
      page_ok = (addr[ADDR_W-1 -: PAGE_W] == page);
      gap_ok  = (addr[ADDR_W-PAGE_W-1 : OFF_W] == '0);
      off_ok  = (addr[OFF_W-1:0] == OFFSET);
      hit     = page_ok && gap_ok && off_ok;
   end
endmodule

// File: rtl/sysopt_window.sv
module sysopt_window #(
   parameter int WINDOW_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic special_mode,
   input  logic wr_hit,
   output logic guard_open
);
   localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WINDOW_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW_CYCLES - 1);

   if (WINDOW_CYCLES < 1) begin : g_bad_window
      $error("sysopt_window: window must be at least one cycle");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
      end else if (!locked_q && ((wr_hit && !special_mode) || cnt_q == CNT_LAST)) begin
         locked_q <= 1'b1;
      end
   end

   assign guard_open = special_mode || !locked_q;
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
   import sysopt_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int PAGE_W        = 4,
   parameter int WINDOW_CYCLES = 64,
   parameter logic [PAGE_W-1:0] HOME_PAGE = 4'h1,
   parameter logic [OPT_W-1:0]  RESET_VAL = OPT_RESET,
   parameter logic [OPT_W-1:0]  GUARD_MASK = OPT_GUARD,
   parameter logic [OPT_W-1:0]  IMPL_MASK  = OPT_IMPL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic [PAGE_W-1:0] page_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [OPT_W-1:0]  wdata,
   output logic [OPT_W-1:0]  rdata,
   output logic [OPT_W-1:0]  opt_bits
);
   if ((GUARD_MASK & ~IMPL_MASK) != '0) begin : g_bad_mask
      $error("sysopt_reg: guarded bit marked unimplemented");
   end

   logic [PAGE_W-1:0] page_eff;
   logic              hit;
   logic              wr_hit;
   logic              guard_open;
   logic [OPT_W-1:0]  opt_q;

   assign page_eff = special_mode ? page_sel : HOME_PAGE;

   sysopt_addr_dec #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .OFF_W  (BLK_OFF_W),
      .OFFSET (OPT_OFFSET)
   ) dec_i (
      .addr (addr),
      .page (page_eff),
      .hit  (hit)
   );

   assign wr_hit = wr_en && hit;

   sysopt_window #(
      .WINDOW_CYCLES (WINDOW_CYCLES)
   ) win_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .special_mode (special_mode),
      .wr_hit       (wr_hit),
      .guard_open   (guard_open)
   );

   for (genvar i = 0; i < OPT_W; i++) begin : g_bit
      localparam bit_kind_e KIND = kind_of(IMPL_MASK[i], GUARD_MASK[i]);
      if (KIND == BIT_ABSENT) begin : g_absent
         assign opt_q[i] = 1'b0;
      end else if (KIND == BIT_GUARD) begin : g_guard
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      opt_q[i] <= RESET_VAL[i];
            else if (wr_hit && guard_open)   opt_q[i] <= wdata[i];
         end
      end else begin : g_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      opt_q[i] <= RESET_VAL[i];
            else if (wr_hit) opt_q[i] <= wdata[i];
         end
      end
   end

   assign opt_bits = opt_q;
   assign rdata    = (rd_en && hit) ? opt_q : '0;
endmodule

// File: rtl/sysopt_reg_chk.sv
module sysopt_reg_chk #(
   parameter int ADDR_W        = 16,
   parameter int PAGE_W        = 4,
   parameter int WINDOW_CYCLES = 64,
   parameter logic [PAGE_W-1:0] HOME_PAGE = 4'h1,
   parameter logic [7:0] RESET_VAL  = 8'h10,
   parameter logic [7:0] GUARD_MASK = 8'h33,
   parameter logic [7:0] IMPL_MASK  = 8'hFB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              special_mode,
   input logic [PAGE_W-1:0] page_sel,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic [7:0]        opt_bits
);
   localparam int CW = $clog2(WINDOW_CYCLES + 1);
   localparam logic [7:0] FREE_MASK = IMPL_MASK & ~GUARD_MASK;

   logic [CW-1:0]     edges;
   logic              wrote;
   logic [PAGE_W-1:0] pg;
   logic              hit_c;

   assign pg    = special_mode ? page_sel : HOME_PAGE;
   assign hit_c = (addr == {pg, {(ADDR_W-PAGE_W-6){1'b0}}, 6'h39});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edges <= '0;
         wrote <= 1'b0;
      end else begin
         if (edges != CW'(WINDOW_CYCLES)) edges <= edges + 1'b1;
         if (wr_en && hit_c && !special_mode) wrote <= 1'b1;
      end
   end

   assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (edges == '0) |-> (opt_bits == RESET_VAL));

   assert_free_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_c) |=> ((opt_bits & FREE_MASK) == ($past(wdata) & FREE_MASK)));

   assert_absent_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~IMPL_MASK) == '0);

   assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wrote && !special_mode) |=> ((opt_bits & GUARD_MASK) == ($past(opt_bits) & GUARD_MASK)));

   assert_window_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edges == CW'(WINDOW_CYCLES) && !special_mode)
      |=> ((opt_bits & GUARD_MASK) == ($past(opt_bits) & GUARD_MASK)));

   assert_no_write_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && hit_c) |=> $stable(opt_bits));

   assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));
endmodule

bind sysopt_reg sysopt_reg_chk #(
   .ADDR_W        (ADDR_W),
   .PAGE_W        (PAGE_W),
   .WINDOW_CYCLES (WINDOW_CYCLES),
   .HOME_PAGE     (HOME_PAGE),
   .RESET_VAL     (RESET_VAL),
   .GUARD_MASK    (GUARD_MASK),
   .IMPL_MASK     (IMPL_MASK)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .special_mode (special_mode),
   .page_sel     (page_sel),
   .addr         (addr),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .wdata        (wdata),
   .rdata        (rdata),
   .opt_bits     (opt_bits)
);

// File: tb/sysopt_reg_tb.sv
module sysopt_reg_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        special_mode = 1'b0;
   logic [3:0]  page_sel = 4'h0;
   logic [15:0] addr = 16'h0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  wdata = 8'h0;
   logic [7:0]  rdata;
   logic [7:0]  opt_bits;

   int checks = 0;
   int errors = 0;
   int cyc;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   sysopt_reg dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .special_mode (special_mode),
      .page_sel     (page_sel),
      .addr         (addr),
      .wr_en        (wr_en),
      .rd_en        (rd_en),
      .wdata        (wdata),
      .rdata        (rdata),
      .opt_bits     (opt_bits)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic mode, input logic [3:0] pg);
      @(negedge clk);
      rst_n = 1'b0;
      special_mode = mode;
      page_sel = pg;
      wr_en = 1'b0;
      rd_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // write lands on the edge whose count since reset release equals at_edge
   task automatic write_at(input logic [15:0] a, input logic [7:0] d, input int at_edge);
      while (cyc < at_edge) @(negedge clk);
      addr = a;
      wdata = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_at(input logic [15:0] a, input logic en, output logic [7:0] v);
      addr = a;
      rd_en = en;
      #1;
      v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset(1'b0, 4'h0);
      check("R1 reset value", opt_bits, 8'h10);
      read_at(16'h1039, 1'b1, v);
      check("R1 R9 reset readback", v, 8'h10);
      read_at(16'h1038, 1'b1, v);
      check("R9 read miss", v, 8'h00);
      read_at(16'h1039, 1'b0, v);
      check("R9 no strobe", v, 8'h00);
   endtask

   task automatic t_once();
      do_reset(1'b0, 4'h0);
      write_at(16'h1039, 8'hFF, 5);
      check("R4 R3 first write", opt_bits, 8'hFB);
      write_at(16'h1039, 8'h00, 10);
      check("R5 second write", opt_bits, 8'h33);
      write_at(16'h1039, 8'hC8, 20);
      check("R2 R10 free bits after lock", opt_bits, 8'hFB);
   endtask

   task automatic t_edge63();
      do_reset(1'b0, 4'h0);
      write_at(16'h1039, 8'h23, 63);
      check("R4 write on edge 63", opt_bits, 8'h23);
   endtask

   task automatic t_edge64();
      do_reset(1'b0, 4'h0);
      write_at(16'h1039, 8'hFF, 64);
      check("R6 write on edge 64", opt_bits, 8'hD8);
      write_at(16'h1039, 8'h00, 80);
      check("R6 R2 late clear", opt_bits, 8'h10);
   endtask

   task automatic t_special();
      do_reset(1'b1, 4'h1);
      write_at(16'h1039, 8'h33, 3);
      check("R7 special first", opt_bits, 8'h33);
      write_at(16'h1039, 8'h00, 10);
      check("R7 special rewrite", opt_bits, 8'h00);
      write_at(16'h1039, 8'h21, 100);
      check("R7 special late", opt_bits, 8'h21);
   endtask

   task automatic t_addr_normal();
      logic [7:0] v;
      do_reset(1'b0, 4'h5);
      write_at(16'h5039, 8'hFF, 2);
      check("R8 page ignored in normal", opt_bits, 8'h10);
      write_at(16'h1038, 8'hFF, 3);
      check("R8 wrong offset", opt_bits, 8'h10);
      write_at(16'h1039, 8'h0C, 4);
      check("R8 R3 home page hit", opt_bits, 8'h08);
      read_at(16'h1039, 1'b1, v);
      check("R9 readback", v, 8'h08);
   endtask

   task automatic t_addr_special();
      logic [7:0] v;
      do_reset(1'b1, 4'h3);
      write_at(16'h1039, 8'h80, 2);
      check("R8 old page ignored", opt_bits, 8'h10);
      write_at(16'h3039, 8'h80, 3);
      check("R8 relocated page", opt_bits, 8'h80);
      read_at(16'h3039, 1'b1, v);
      check("R9 relocated read", v, 8'h80);
   endtask

   initial begin
      t_reset();
      t_once();
      t_edge63();
      t_edge64();
      t_special();
      t_addr_normal();
      t_addr_special();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule